// File: doc/BRIEF.md
# Codec Command and Response Ring Engine

This block feeds an audio codec link from two circular buffers in system memory. Software places 32-bit command words in an outbound ring and advances a write pointer. The engine fetches each word over a simple request/acknowledge memory port and checks its address fields. It then issues the word on a command-out port, or drops it. Every response that comes back from the codec is written as a two-word entry into an inbound ring. The engine counts stored responses against a programmable threshold and raises a ring interrupt flag. Software clears that flag to reset the count and let fetching resume.

A second path bypasses both rings. Software loads one command into an immediate register and sets a busy bit. The engine sends that command and latches the next response into an immediate response register. It then reports the result in a small status byte. Only one command, from either path, is in flight at a time.

The sequencer has seven states. IDLE arbitrates among work sources. FETCH reads a ring word. ISSUE forwards or drops it. STORE_DATA and STORE_EXT write the two words of a response entry. IMM_SEND sends the immediate command and IMM_WAIT waits for its reply. The transitions are:
- IDLE→STORE_DATA on a response while storing is enabled. With storing disabled the response is dropped and the engine stays in IDLE.
- IDLE→IMM_SEND when busy is set and nothing is outstanding.
- IDLE→FETCH when a ring fetch is allowed.
- FETCH→ISSUE on acknowledge.
- ISSUE→IDLE.
- STORE_DATA→STORE_EXT on acknowledge.
- STORE_EXT→IDLE on acknowledge.
- IMM_SEND→IMM_WAIT for a legal command, IMM_SEND→IDLE for a rejected one.
- IMM_WAIT→IDLE on a response.

Configuration writes use `cfg_addr`:
- 0: command ring base.
- 1: response ring base.
- 2: command write pointer.
- 3: control. Bit 0 is run, bit 1 enables response storing, bit 2 enables the ring interrupt.
- 4: response threshold.
- 5: ring status. Write 1 to bit 0 to clear the flag.
- 6: response write pointer control. Bit 15 is the reset bit.
- 7: immediate command.
- 8: immediate status. Write 1 to bit 0 to set busy, write 1 to bit 1 to clear valid.

Top module: `cmd_resp_ring_engine`

## Requirements
- R1: A command word carries its codec address in bits 31:28, an indirect flag in bit 27, a node number in bits 26:20 and a payload in bits 19:0. A word with bit 27 set, or one addressing a codec whose `codec_present` bit is 0, is never driven on `cmd_valid`. This applies on both paths. A rejected immediate command clears busy without setting valid.
- R2: Each ring fetch first advances `cmd_rd_ptr` by one, modulo 256. It then reads the word at command base + 4 × pointer, and words go out in ring order.
- R3: No fetch starts while the run bit (control bit 0) is 0, while `cmd_rd_ptr` equals the command write pointer, or while `rsp_count` equals the threshold.
- R4: A stored response advances `rsp_wr_ptr` by one, modulo 256. It then writes the response word at response base + 8 × pointer, followed by an extension word at +4. The extension word has bit 4 set for an unsolicited response and holds the codec address in bits 3:0.
- R5: With response storing disabled (control bit 1 = 0), responses are discarded. There is no memory write and no change to `rsp_wr_ptr` or `rsp_count`.
- R6: When a response entry is complete and the interrupt enable (control bit 2) is set, `ring_irq` is set if `rsp_count` equals the threshold or the command ring is empty.
- R7: Writing 1 to ring status bit 0 clears `ring_irq` and `rsp_count`, which restarts fetching.
- R8: Setting immediate busy sends the immediate command. The reply goes to `imm_resp` and never to the ring. `imm_status` then reads codec address in bits 7:4, valid in bit 1 and busy in bit 0, with busy cleared. Writing 1 to status bit 1 clears valid.
- R9: Writing the response pointer control with bit 15 set returns `rsp_wr_ptr` to 0.
- R10: After a command is issued, no further command is fetched or sent until a solicited response to it has been accepted, stored or dropped.
- R11: A memory request holds its address, direction and data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| codec_present | input | 16 | One bit per codec address that is attached |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| cmd_valid | output | 1 | One-cycle command strobe toward the codec |
| cmd_word | output | 32 | Command word |
| rsp_valid | input | 1 | Codec response available |
| rsp_data | input | 32 | Response word |
| rsp_unsol | input | 1 | Response was not solicited |
| rsp_cad | input | 4 | Address of the responding codec |
| rsp_ready | output | 1 | Response accepted when high with `rsp_valid` |
| cmd_rd_ptr | output | 8 | Command ring read pointer |
| rsp_wr_ptr | output | 8 | Response ring write pointer |
| rsp_count | output | 8 | Responses stored since the last flag clear |
| ring_irq | output | 1 | Ring interrupt flag |
| imm_resp | output | 32 | Immediate response register |
| imm_status | output | 8 | Immediate status: codec address, valid, busy |

## Verification
A ring fetch moves `cmd_rd_ptr` on the edge that leaves IDLE. `cmd_valid` follows two cycles later with a zero-wait memory, plus one cycle for each stall cycle. A response accepted in IDLE becomes a finished entry after two acknowledged writes, and `ring_irq` rises on the edge of the second acknowledge. Configuration effects such as a flag clear, a pointer reset or a busy set are visible on the first falling edge after the write edge, and are checked there. Multi-step results are checked only after a settling wait that is longer than the worst fetch–respond–store round trip. All outputs are sampled on falling edges.

// File: rtl/cre_pkg.sv
package cre_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_ISSUE,
        S_STORE_DATA,
        S_STORE_EXT,
        S_IMM_SEND,
        S_IMM_WAIT
    } cre_state_t;

    localparam int CFG_AW = 4;
    localparam logic [CFG_AW-1:0] REG_CMD_BASE = 4'd0;
    localparam logic [CFG_AW-1:0] REG_RSP_BASE = 4'd1;
    localparam logic [CFG_AW-1:0] REG_CMD_WP   = 4'd2;
    localparam logic [CFG_AW-1:0] REG_CTRL     = 4'd3;
    localparam logic [CFG_AW-1:0] REG_THRESH   = 4'd4;
    localparam logic [CFG_AW-1:0] REG_RING_STS = 4'd5;
    localparam logic [CFG_AW-1:0] REG_RSP_WP   = 4'd6;
    localparam logic [CFG_AW-1:0] REG_IMM_CMD  = 4'd7;
    localparam logic [CFG_AW-1:0] REG_IMM_STS  = 4'd8;

    localparam int CTRL_RUN     = 0;
    localparam int CTRL_STORE   = 1;
    localparam int CTRL_IRQ_EN  = 2;
    localparam int WP_RESET_BIT = 15;

    localparam int CMD_CAD_LSB   = 28;
    localparam int CMD_INDIRECT  = 27;
    localparam int EXT_UNSOL_BIT = 4;
endpackage

// File: rtl/cre_ring_ptr.sv
module cre_ring_ptr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ptr <= '0;
        else if (clr) ptr <= '0;
        else if (inc) ptr <= ptr + W'(1);
    end
endmodule

// File: rtl/cre_cmd_check.sv
module cre_cmd_check
    import cre_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CAD_W  = 4
) (
    input  logic [DATA_W-1:0]      word,
    input  logic [(1<<CAD_W)-1:0]  present,
    output logic                   ok
);
    logic [CAD_W-1:0] cad;
    assign cad = word[CMD_CAD_LSB +: CAD_W];
    assign ok  = !word[CMD_INDIRECT] && present[cad];
endmodule

// File: rtl/cmd_resp_ring_engine.sv
module cmd_resp_ring_engine
    import cre_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PTR_W  = 8,
    parameter int CAD_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    input  logic [(1<<CAD_W)-1:0] codec_present,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic                  mem_ack,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  cmd_valid,
    output logic [DATA_W-1:0]     cmd_word,
    input  logic                  rsp_valid,
    input  logic [DATA_W-1:0]     rsp_data,
    input  logic                  rsp_unsol,
    input  logic [CAD_W-1:0]      rsp_cad,
    output logic                  rsp_ready,
    output logic [PTR_W-1:0]      cmd_rd_ptr,
    output logic [PTR_W-1:0]      rsp_wr_ptr,
    output logic [PTR_W-1:0]      rsp_count,
    output logic                  ring_irq,
    output logic [DATA_W-1:0]     imm_resp,
    output logic [CAD_W+3:0]      imm_status
);
    localparam int CMD_STRIDE_SH = 2;
    localparam int RSP_STRIDE_SH = 3;

    cre_state_t state_q, state_d;

    logic [ADDR_W-1:0] cmd_base_q, rsp_base_q;
    logic [PTR_W-1:0]  cmd_wp_q, thresh_q, cnt_q;
    logic              run_q, store_en_q, irq_en_q, irq_q;
    logic              awaiting_q;
    logic [DATA_W-1:0] fetched_q, imm_cmd_q, imm_resp_q;
    logic [DATA_W-1:0] rsp_data_q, rsp_ext_q, ext_word;
    logic              imm_busy_q, imm_valid_q;
    logic [CAD_W-1:0]  imm_cad_q;

    logic ring_ok, imm_ok, fetch_ok, rd_inc, wr_inc, wr_clr, rsp_take;

    cre_cmd_check #(.DATA_W(DATA_W), .CAD_W(CAD_W)) u_ring_chk (
        .word(fetched_q), .present(codec_present), .ok(ring_ok));
    cre_cmd_check #(.DATA_W(DATA_W), .CAD_W(CAD_W)) u_imm_chk (
        .word(imm_cmd_q), .present(codec_present), .ok(imm_ok));

    cre_ring_ptr #(.W(PTR_W)) u_rd_ptr (
        .clk(clk), .rst_n(rst_n), .inc(rd_inc), .clr(1'b0), .ptr(cmd_rd_ptr));
    cre_ring_ptr #(.W(PTR_W)) u_wr_ptr (
        .clk(clk), .rst_n(rst_n), .inc(wr_inc), .clr(wr_clr), .ptr(rsp_wr_ptr));

    assign rsp_take = (state_q == S_IDLE) && rsp_valid;
    assign fetch_ok = run_q && (cmd_rd_ptr != cmd_wp_q) && (cnt_q != thresh_q) && !awaiting_q;
    assign rd_inc   = (state_q == S_IDLE) && (state_d == S_FETCH);
    assign wr_inc   = rsp_take && store_en_q;
    assign wr_clr   = cfg_wr && (cfg_addr == REG_RSP_WP) && cfg_wdata[WP_RESET_BIT];

    always_comb begin
        ext_word = '0;
        ext_word[CAD_W-1:0]    = rsp_cad;
        ext_word[EXT_UNSOL_BIT] = rsp_unsol;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (rsp_valid) begin
                    if (store_en_q) state_d = S_STORE_DATA;
                end else if (imm_busy_q && !awaiting_q) begin
                    state_d = S_IMM_SEND;
                end else if (fetch_ok) begin
                    state_d = S_FETCH;
                end
            end
            S_FETCH:      if (mem_ack) state_d = S_ISSUE;
            S_ISSUE:      state_d = S_IDLE;
            S_STORE_DATA: if (mem_ack) state_d = S_STORE_EXT;
            S_STORE_EXT:  if (mem_ack) state_d = S_IDLE;
            S_IMM_SEND:   state_d = imm_ok ? S_IMM_WAIT : S_IDLE;
            S_IMM_WAIT:   if (rsp_valid) state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cmd_base_q + (ADDR_W'(cmd_rd_ptr) << CMD_STRIDE_SH);
        mem_wdata = rsp_data_q;
        cmd_valid = 1'b0;
        cmd_word  = fetched_q;
        rsp_ready = 1'b0;
        unique case (state_q)
            S_IDLE:       rsp_ready = 1'b1;
            S_FETCH:      mem_req = 1'b1;
            S_ISSUE:      cmd_valid = ring_ok;
            S_STORE_DATA: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = rsp_base_q + (ADDR_W'(rsp_wr_ptr) << RSP_STRIDE_SH);
            end
            S_STORE_EXT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = rsp_base_q + (ADDR_W'(rsp_wr_ptr) << RSP_STRIDE_SH) + ADDR_W'(4);
                mem_wdata = rsp_ext_q;
            end
            S_IMM_SEND: begin
                cmd_valid = imm_ok;
                cmd_word  = imm_cmd_q;
            end
            S_IMM_WAIT:   rsp_ready = 1'b1;
            default:      ;
        endcase
    end

    // datapath and register file; sequencer actions follow software writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_base_q <= '0; rsp_base_q <= '0; cmd_wp_q <= '0; thresh_q <= '0;
            cnt_q <= '0; run_q <= 1'b0; store_en_q <= 1'b0; irq_en_q <= 1'b0;
            irq_q <= 1'b0; awaiting_q <= 1'b0; fetched_q <= '0; imm_cmd_q <= '0;
            imm_resp_q <= '0; rsp_data_q <= '0; rsp_ext_q <= '0;
            imm_busy_q <= 1'b0; imm_valid_q <= 1'b0; imm_cad_q <= '0;
        end else begin
            if (cfg_wr) begin
                unique case (cfg_addr)
                    REG_CMD_BASE: cmd_base_q <= ADDR_W'(cfg_wdata);
                    REG_RSP_BASE: rsp_base_q <= ADDR_W'(cfg_wdata);
                    REG_CMD_WP:   cmd_wp_q   <= cfg_wdata[PTR_W-1:0];
                    REG_CTRL: begin
                        run_q      <= cfg_wdata[CTRL_RUN];
                        store_en_q <= cfg_wdata[CTRL_STORE];
                        irq_en_q   <= cfg_wdata[CTRL_IRQ_EN];
                    end
                    REG_THRESH:   thresh_q <= cfg_wdata[PTR_W-1:0];
                    REG_RING_STS: if (cfg_wdata[0]) begin
                        irq_q <= 1'b0;
                        cnt_q <= '0;
                    end
                    REG_IMM_CMD:  imm_cmd_q <= cfg_wdata;
                    REG_IMM_STS: begin
                        if (cfg_wdata[0]) imm_busy_q  <= 1'b1;
                        if (cfg_wdata[1]) imm_valid_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (rsp_take) begin
                if (!rsp_unsol) awaiting_q <= 1'b0;
                if (store_en_q) begin
                    rsp_data_q <= rsp_data;
                    rsp_ext_q  <= ext_word;
                    cnt_q      <= cnt_q + PTR_W'(1);
                end
            end
            if (state_q == S_FETCH && mem_ack) fetched_q <= mem_rdata;
            if (state_q == S_ISSUE && ring_ok) awaiting_q <= 1'b1;
            if (state_q == S_STORE_EXT && mem_ack && irq_en_q &&
                ((cnt_q == thresh_q) || (cmd_rd_ptr == cmd_wp_q)))
                irq_q <= 1'b1;
            if (state_q == S_IMM_SEND && !imm_ok) imm_busy_q <= 1'b0;
            if (state_q == S_IMM_WAIT && rsp_valid) begin
                imm_resp_q  <= rsp_data;
                imm_busy_q  <= 1'b0;
                imm_valid_q <= 1'b1;
                imm_cad_q   <= rsp_cad;
            end
        end
    end

    assign rsp_count  = cnt_q;
    assign ring_irq   = irq_q;
    assign imm_resp   = imm_resp_q;
    assign imm_status = {imm_cad_q, 2'b00, imm_valid_q, imm_busy_q};
endmodule

// File: rtl/cre_checker.sv
module cre_checker
    import cre_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PTR_W  = 8,
    parameter int CAD_W  = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mem_req,
    input logic                  mem_we,
    input logic                  mem_ack,
    input logic [ADDR_W-1:0]     mem_addr,
    input logic [DATA_W-1:0]     mem_wdata,
    input logic                  cmd_valid,
    input logic [DATA_W-1:0]     cmd_word,
    input logic [(1<<CAD_W)-1:0] codec_present,
    input logic                  ring_irq,
    input logic [PTR_W-1:0]      rsp_wr_ptr,
    input logic [PTR_W-1:0]      cmd_rd_ptr
);
    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_cmd_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (!cmd_word[CMD_INDIRECT] && codec_present[cmd_word[CMD_CAD_LSB +: CAD_W]]));

    assert_irq_after_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ring_irq) |-> $past(mem_req && mem_we && mem_ack));

    assert_wptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsp_wr_ptr) |-> ((rsp_wr_ptr == $past(rsp_wr_ptr) + PTR_W'(1)) || (rsp_wr_ptr == '0)));

    assert_fetch_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_rd_ptr) |-> (mem_req && !mem_we && (cmd_rd_ptr == $past(cmd_rd_ptr) + PTR_W'(1))));

    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
endmodule

bind cmd_resp_ring_engine cre_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .CAD_W(CAD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .codec_present(codec_present), .ring_irq(ring_irq), .rsp_wr_ptr(rsp_wr_ptr),
    .cmd_rd_ptr(cmd_rd_ptr)
);

// File: tb/cmd_resp_ring_engine_tb.sv
`timescale 1ns/1ps
module cmd_resp_ring_engine_tb;
    localparam logic [31:0] CMD_BASE = 32'h0000_1000;
    localparam logic [31:0] RSP_BASE = 32'h0000_8000;
    localparam logic [31:0] KEY      = 32'h0F0F_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] codec_present = 16'h0003;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        cmd_valid;
    logic [31:0] cmd_word;
    logic        rsp_valid = 1'b0, rsp_unsol = 1'b0, rsp_ready;
    logic [31:0] rsp_data = '0;
    logic [3:0]  rsp_cad = '0;
    logic [7:0]  cmd_rd_ptr, rsp_wr_ptr, rsp_count;
    logic        ring_irq;
    logic [31:0] imm_resp;
    logic [7:0]  imm_status;

    always #4 clk = ~clk;

    cmd_resp_ring_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .codec_present(codec_present), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .cmd_valid(cmd_valid),
        .cmd_word(cmd_word), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_unsol(rsp_unsol),
        .rsp_cad(rsp_cad), .rsp_ready(rsp_ready), .cmd_rd_ptr(cmd_rd_ptr), .rsp_wr_ptr(rsp_wr_ptr),
        .rsp_count(rsp_count), .ring_irq(ring_irq), .imm_resp(imm_resp), .imm_status(imm_status));

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // memory model
    logic [31:0] cmem [0:255];
    logic [31:0] rmem [0:511];
    int mem_stall = 0, wcnt = 0, wr_n = 0;
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            if (wcnt >= mem_stall) begin
                wcnt    <= 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    rmem[9'((mem_addr - RSP_BASE) >> 2)] <= mem_wdata;
                    wr_n <= wr_n + 1;
                end else begin
                    mem_rdata <= cmem[8'((mem_addr - CMD_BASE) >> 2)];
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // request-hold monitor
    int hold_viol = 0;
    logic prev_pend = 1'b0;
    logic [31:0] prev_addr = '0;
    always @(negedge clk) begin
        if (prev_pend && (!mem_req || mem_addr != prev_addr)) hold_viol++;
        prev_pend = mem_req && !mem_ack;
        prev_addr = mem_addr;
    end

    // codec model
    logic [31:0] cmd_log [0:63];
    int cmd_n = 0;
    bit auto_resp = 0;
    always @(negedge clk) if (cmd_valid) begin
        if (cmd_n < 64) cmd_log[cmd_n] = cmd_word;
        cmd_n++;
    end

    task automatic send_rsp(input logic [31:0] d, input logic u, input logic [3:0] c);
        rsp_valid = 1'b1; rsp_data = d; rsp_unsol = u; rsp_cad = c;
        while (!rsp_ready) @(negedge clk);
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    always begin
        @(negedge clk);
        if (cmd_valid && auto_resp) begin
            logic [31:0] w;
            w = cmd_word;
            @(negedge clk);
            @(negedge clk);
            send_rsp(w ^ KEY, 1'b0, w[31:28]);
        end
    end

    function automatic logic [31:0] mk(input logic [3:0] cad, input logic [6:0] nid, input logic [19:0] pl);
        return {cad, 1'b0, nid, pl};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input bit run, input bit store, input bit irq, input logic [7:0] thr);
        auto_resp = 0; mem_stall = 0; cmd_n = 0; wr_n = 0; hold_viol = 0;
        codec_present = 16'h0003;
        for (int i = 0; i < 256; i++) cmem[i] = '0;
        for (int i = 0; i < 512; i++) rmem[i] = '0;
        @(negedge clk); rst_n = 1'b0;
        wait_cyc(3); rst_n = 1'b1;
        @(negedge clk);
        cfg_write(4'd0, CMD_BASE);
        cfg_write(4'd1, RSP_BASE);
        cfg_write(4'd4, {24'd0, thr});
        cfg_write(4'd3, {29'd0, irq, store, run});
    endtask

    task automatic t_reset();
        setup(0, 0, 0, 8'd0);
        chk("R2 reset rd ptr", cmd_rd_ptr, 0);
        chk("R4 reset wr ptr", rsp_wr_ptr, 0);
        chk("R6 reset irq", ring_irq, 0);
        chk("R8 reset imm status", imm_status, 0);
        chk("R11 reset no request", mem_req, 0);
    endtask

    task automatic t_ring_basic();
        logic [31:0] a, b;
        setup(1, 1, 1, 8'd10);
        a = mk(4'd0, 7'd1, 20'h00A11); b = mk(4'd1, 7'd2, 20'h00B22);
        cmem[1] = a; cmem[2] = b; auto_resp = 1;
        cfg_write(4'd2, 32'd2);
        wait_cyc(60);
        chk("R2 two sent", cmd_n, 2);
        chk("R2 order first", cmd_log[0], a);
        chk("R2 order second", cmd_log[1], b);
        chk("R3 stops at wp", cmd_rd_ptr, 2);
        chk("R4 wr ptr", rsp_wr_ptr, 2);
        chk("R4 entry1 data", rmem[2], a ^ KEY);
        chk("R4 entry1 ext", rmem[3], 32'h0);
        chk("R4 entry2 data", rmem[4], b ^ KEY);
        chk("R4 entry2 ext", rmem[5], 32'h1);
        chk("R6 irq on empty ring", ring_irq, 1);
        chk("R6 count", rsp_count, 2);
    endtask

    task automatic t_one_outstanding();
        setup(1, 1, 0, 8'd10);
        cmem[1] = mk(4'd0, 7'd3, 20'h1); cmem[2] = mk(4'd1, 7'd3, 20'h2);
        cfg_write(4'd2, 32'd2);
        wait_cyc(20);
        chk("R10 one sent while waiting", cmd_n, 1);
        chk("R10 rd ptr held", cmd_rd_ptr, 1);
        send_rsp(32'h1234, 1'b0, 4'd0);
        wait_cyc(20);
        chk("R10 next sent after reply", cmd_n, 2);
        chk("R10 rd ptr advanced", cmd_rd_ptr, 2);
        send_rsp(32'h5678, 1'b0, 4'd1);
        wait_cyc(10);
    endtask

    task automatic t_reject();
        setup(1, 1, 0, 8'd10);
        cmem[1] = {4'd0, 1'b1, 7'd1, 20'h1};
        cmem[2] = mk(4'd5, 7'd1, 20'h2);
        cmem[3] = mk(4'd1, 7'd1, 20'h3);
        auto_resp = 1;
        cfg_write(4'd2, 32'd3);
        wait_cyc(60);
        chk("R1 only legal sent", cmd_n, 1);
        chk("R1 legal word", cmd_log[0], cmem[3]);
        chk("R1 pointer past dropped", cmd_rd_ptr, 3);
    endtask

    task automatic t_run_gate();
        setup(0, 1, 0, 8'd10);
        cmem[1] = mk(4'd0, 7'd4, 20'h4); auto_resp = 1;
        cfg_write(4'd2, 32'd1);
        wait_cyc(20);
        chk("R3 no fetch without run", cmd_rd_ptr, 0);
        chk("R3 nothing sent", cmd_n, 0);
        cfg_write(4'd3, 32'h3);
        wait_cyc(30);
        chk("R3 fetch after run", cmd_rd_ptr, 1);
        chk("R3 sent after run", cmd_n, 1);
    endtask

    task automatic t_threshold();
        setup(1, 1, 1, 8'd1);
        for (int i = 1; i <= 3; i++) cmem[i] = mk(4'd1, 7'(i), 20'(i));
        auto_resp = 1;
        cfg_write(4'd2, 32'd3);
        wait_cyc(60);
        chk("R3 stall at threshold", cmd_n, 1);
        chk("R3 rd ptr at threshold", cmd_rd_ptr, 1);
        chk("R6 irq at threshold", ring_irq, 1);
        cfg_write(4'd5, 32'h1);
        chk("R7 clear flag", ring_irq, 0);
        chk("R7 clear count", rsp_count, 0);
        wait_cyc(60);
        chk("R7 fetch resumed", cmd_n, 2);
        chk("R7 rd ptr resumed", cmd_rd_ptr, 2);
        chk("R7 count again", rsp_count, 1);
    endtask

    task automatic t_store_off();
        setup(1, 0, 1, 8'd10);
        cmem[1] = mk(4'd0, 7'd5, 20'h5); auto_resp = 1;
        cfg_write(4'd2, 32'd1);
        wait_cyc(40);
        chk("R5 cmd sent", cmd_n, 1);
        send_rsp(32'hDEAD, 1'b1, 4'd2);
        wait_cyc(10);
        chk("R5 wr ptr unchanged", rsp_wr_ptr, 0);
        chk("R5 count unchanged", rsp_count, 0);
        chk("R5 no memory writes", wr_n, 0);
        chk("R5 no irq", ring_irq, 0);
        cmem[2] = mk(4'd1, 7'd5, 20'h6);
        cfg_write(4'd2, 32'd2);
        wait_cyc(40);
        chk("R10 drop frees next fetch", cmd_n, 2);
    endtask

    task automatic t_unsol_wp_reset();
        setup(0, 1, 1, 8'd10);
        send_rsp(32'hAAAA_0001, 1'b1, 4'd3);
        wait_cyc(15);
        chk("R4 unsol wr ptr", rsp_wr_ptr, 1);
        chk("R4 unsol data", rmem[2], 32'hAAAA_0001);
        chk("R4 unsol ext", rmem[3], 32'h13);
        chk("R6 irq on empty ring unsol", ring_irq, 1);
        send_rsp(32'hBBBB_0002, 1'b1, 4'd2);
        wait_cyc(15);
        chk("R4 second entry", rmem[4], 32'hBBBB_0002);
        cfg_write(4'd6, 32'h8000);
        chk("R9 wr ptr reset", rsp_wr_ptr, 0);
        send_rsp(32'hCCCC_0003, 1'b0, 4'd0);
        wait_cyc(15);
        chk("R9 reuse entry 1", rmem[2], 32'hCCCC_0003);
        chk("R9 reuse ext", rmem[3], 32'h0);
        chk("R9 ptr after reuse", rsp_wr_ptr, 1);
    endtask

    task automatic t_immediate();
        logic [31:0] w;
        setup(0, 1, 0, 8'd10);
        auto_resp = 1;
        w = mk(4'd1, 7'd9, 20'h9ABC);
        cfg_write(4'd7, w);
        cfg_write(4'd8, 32'h1);
        chk("R8 busy set", imm_status, 8'h01);
        wait_cyc(20);
        chk("R8 imm sent", cmd_log[0], w);
        chk("R8 imm response", imm_resp, w ^ KEY);
        chk("R8 status valid cad", imm_status, 8'h12);
        chk("R8 ring untouched", rsp_wr_ptr, 0);
        cfg_write(4'd8, 32'h2);
        chk("R8 valid cleared", imm_status, 8'h10);
        cfg_write(4'd7, {4'd1, 1'b1, 7'd9, 20'h1});
        cfg_write(4'd8, 32'h1);
        wait_cyc(10);
        chk("R1 imm rejected not sent", cmd_n, 1);
        chk("R1 imm rejected clears busy", imm_status, 8'h10);
    endtask

    task automatic t_mem_stall();
        setup(1, 1, 0, 8'd10);
        mem_stall = 3;
        cmem[1] = mk(4'd0, 7'd7, 20'h7); auto_resp = 1;
        cfg_write(4'd2, 32'd1);
        wait_cyc(80);
        chk("R11 request held", hold_viol, 0);
        chk("R11 cmd through stalls", cmd_log[0], cmem[1]);
        chk("R11 stored through stalls", rmem[2], cmem[1] ^ KEY);
    endtask

    initial begin
        t_reset();
        t_ring_basic();
        t_one_outstanding();
        t_reject();
        t_run_gate();
        t_threshold();
        t_store_off();
        t_unsol_wp_reset();
        t_immediate();
        t_mem_stall();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule